// File: doc/BRIEF.md
# Key-Locked Watchdog Reset Timer

This block is a watchdog whose configuration is protected by an unlock code. Software first writes a 16-bit code to the key register. Only while the block is unlocked do writes to the timer register (the down-counter) and to the control register (reset-enable, count-enable, interrupt-enable) take effect. Any other value written to the key register locks the block again. Once counting is enabled, the timer drops by one every clock. When it reaches zero and reset is enabled, the block sends out a system reset pulse of fixed length. If reset is not enabled, it can raise an interrupt instead, and the count holds at zero.

Loading a zero count and then enabling counting and reset is the way to request a reset at once. When a pulse fires, the block wipes itself back to its power-on state: locked, timer zero, all enables clear. It ignores every write until the pulse has ended.

Register access is a single-cycle write strobe with a 2-bit select, plus a combinational read port on a separate select.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is locked, and these read as zero: the key readback, the timer and the control register. Both irq_o and wdt_rst_o are low. The select encoding for both the read and write ports is 0 = key, 1 = timer, 2 = control.
- R2: Writing 0x482E to the key register unlocks the block, and key readback returns 1. Writing any other 16-bit value locks it, and key readback returns 0.
- R3: While the block is locked, writes to the timer and control registers leave both unchanged.
- R4: With count-enable set and the timer non-zero, the timer decreases by one on every clock. An unlocked timer write loads the written value, and it takes priority over that cycle's decrement.
- R5: When the timer is zero while both count-enable and reset-enable are set, wdt_rst_o rises on the next clock edge. A timer of T loaded before a control write of 3 gives the rise T+1 edges after that write. With count-enable clear, no reset is produced.
- R6: Writing zero to the timer and then writing 3 to the control register makes wdt_rst_o rise on the first edge after the control write.
- R7: wdt_rst_o stays high for exactly 16 clocks. Afterwards the block is locked and the timer and control read zero. Key, timer and control writes made during the pulse have no effect.
- R8: With count-enable and interrupt-enable set and reset-enable clear, irq_o is high while the timer is zero. The timer holds at zero rather than wrapping. irq_o stays low if interrupt-enable is clear.
- R9: If an unlocked timer write arrives in the same cycle that a reset expiry is pending, the expiry wins. The pulse starts, and the written value is discarded.
- R10: The control register holds reset-enable in bit 0, count-enable in bit 1 and interrupt-enable in bit 2. An unlocked write to it reads back the written 3-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 key, 1 timer, 2 control |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read target: 0 key, 1 timer, 2 control |
| rd_data | output | 16 | Read data for rd_sel |
| irq_o | output | 1 | Expiry interrupt, level |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
Two events can land on the same edge. One is a software reload of the timer, the usual watchdog kick. The other is the expiry of a count that already sits at zero with reset enabled. The bench counts the timer down to zero, then drives an unlocked timer write exactly in the cycle the expiry is pending. It requires the pulse to start on that edge and the timer to read zero afterwards, not the reloaded value. A similar overlap, with writes landing during an active pulse, is judged by reading the key, timer and control registers once the pulse ends.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [1:0] {
    SEL_KEY   = 2'd0,
    SEL_TIMER = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_SPARE = 2'd3
  } kwdt_sel_e;

  // bit 2 irq_en, bit 1 cnt_en, bit 0 rst_en
  typedef struct packed {
    logic irq_en;
    logic cnt_en;
    logic rst_en;
  } kwdt_ctrl_t;

  localparam int CTRL_W = 3;

endpackage

// File: rtl/kwdt_lock.sv
module kwdt_lock #(
  parameter int              KEY_W     = 16,
  parameter logic [KEY_W-1:0] KEY_VALUE = 16'h482E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             wipe,
  output logic             unlocked_o
);

  logic unlocked_q, unlocked_d, lock_ce;

  always_comb begin
    lock_ce    = wipe | key_wr;
    unlocked_d = unlocked_q;
    if (wipe)        unlocked_d = 1'b0;
    else if (key_wr) unlocked_d = (key_data == KEY_VALUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unlocked_q <= 1'b0;
    else if (lock_ce) unlocked_q <= unlocked_d;
  end

  assign unlocked_o = unlocked_q;

  // R2: unlocking only follows a write of the code
  a_r2_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(key_wr && (key_data == KEY_VALUE)));

  // R2: a wrong code locks
  a_r2_wrong_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && (key_data != KEY_VALUE)) |=> !unlocked_o);

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_we,
  input  logic [CNT_W-1:0] timer_in,
  input  logic             ctrl_we,
  input  kwdt_ctrl_t       ctrl_in,
  input  logic             wipe,
  output logic [CNT_W-1:0] cnt_o,
  output kwdt_ctrl_t       ctrl_o,
  output logic             expire_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  kwdt_ctrl_t       ctrl_q, ctrl_d;
  logic             cnt_ce, ctrl_ce, is_zero, stepping;

  always_comb begin
    is_zero  = (cnt_q == '0);
    stepping = ctrl_q.cnt_en & ~is_zero;
    cnt_ce   = wipe | timer_we | stepping;
    cnt_d    = cnt_q;
    if (wipe)          cnt_d = '0;
    else if (timer_we) cnt_d = timer_in;
    else if (stepping) cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    ctrl_ce = wipe | ctrl_we;
    ctrl_d  = wipe ? '0 : ctrl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  assign cnt_o    = cnt_q;
  assign ctrl_o   = ctrl_q;
  assign expire_o = ctrl_q.cnt_en & ctrl_q.rst_en & is_zero;
  assign irq_o    = ctrl_q.cnt_en & ~ctrl_q.rst_en & ctrl_q.irq_en & is_zero;

  // R4: one step down per clock while counting
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.cnt_en && (cnt_q != '0) && !timer_we && !wipe) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: no wrap below zero
  a_r8_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !timer_we) |=> (cnt_q == '0));

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic rst_o
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          on_q, on_d, pulse_ce;
  logic [PW-1:0] left_q, left_d;

  always_comb begin
    pulse_ce = fire_i | on_q;
    on_d     = on_q;
    left_d   = left_q;
    if (on_q) begin
      if (left_q == '0) on_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end else if (fire_i) begin
      on_d   = 1'b1;
      left_d = PW'(PULSE_LEN - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      left_q <= '0;
    end else if (pulse_ce) begin
      on_q   <= on_d;
      left_q <= left_d;
    end
  end

  assign rst_o = on_q;

  // checker-only length counter
  logic [PW:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_len <= '0;
    else if (on_q)  hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  // R7: pulse lasts exactly PULSE_LEN clocks
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (hi_len == (PW+1)'(PULSE_LEN)));

  // R5: pulse only starts after an expiry
  a_r5_rise_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(fire_i));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] KEY_VALUE = 16'h482E,
  parameter int                PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  localparam int KEY_W = DATA_W;
  localparam int CNT_W = DATA_W;

  kwdt_sel_e        wsel, rsel;
  logic             busy, unlocked, fire, access_ok;
  logic             key_wr, timer_we, ctrl_we;
  logic [CNT_W-1:0] cnt;
  kwdt_ctrl_t       ctrl, ctrl_in;

  always_comb begin
    wsel      = kwdt_sel_e'(wr_sel);
    rsel      = kwdt_sel_e'(rd_sel);
    access_ok = wr_en & ~busy;
    key_wr    = access_ok & (wsel == SEL_KEY);
    timer_we  = access_ok & unlocked & (wsel == SEL_TIMER);
    ctrl_we   = access_ok & unlocked & (wsel == SEL_CTRL);
    ctrl_in   = kwdt_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  kwdt_lock #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (key_wr),
    .key_data   (wr_data[KEY_W-1:0]),
    .wipe       (fire),
    .unlocked_o (unlocked)
  );

  kwdt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .timer_we (timer_we),
    .timer_in (wr_data[CNT_W-1:0]),
    .ctrl_we  (ctrl_we),
    .ctrl_in  (ctrl_in),
    .wipe     (fire),
    .cnt_o    (cnt),
    .ctrl_o   (ctrl),
    .expire_o (fire),
    .irq_o    (irq_o)
  );

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .rst_o  (busy)
  );

  assign wdt_rst_o = busy;

  always_comb begin
    rd_data = '0;
    unique case (rsel)
      SEL_KEY:   rd_data = DATA_W'(unlocked);
      SEL_TIMER: rd_data = DATA_W'(cnt);
      SEL_CTRL:  rd_data = DATA_W'(ctrl);
      default:   rd_data = '0;
    endcase
  end

  // R3: locked timer write has no effect on an idle counter
  a_r3_locked_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wsel == SEL_TIMER) && !unlocked && !ctrl.cnt_en && !fire) |=> $stable(cnt));

  // R3: locked control write has no effect
  a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wsel == SEL_CTRL) && !unlocked && !fire) |=> $stable(ctrl));

  // R7: block sits in its reset state during the pulse
  a_r7_quiet_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> (!irq_o && !unlocked && (cnt == '0)));

  // R9: expiry always wins over a same-cycle timer write
  a_r9_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy) |=> (wdt_rst_o && (cnt == '0)));

endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

  localparam int KEY = 16'h482E;
  localparam int PLEN = 16;

  logic        clk, rst_n, wr_en;
  logic [1:0]  wr_sel, rd_sel;
  logic [15:0] wr_data, rd_data;
  logic        irq_o, wdt_rst_o;

  int nchk = 0;
  int nfail = 0;

  keyed_watchdog dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic wr(input logic [1:0] s, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    rd_sel = s;
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_rst(output int k);
    k = 0;
    while (!wdt_rst_o && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (wdt_rst_o && w < 200) begin w++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int v, k, w;
    int keys[6] = '{0, KEY, KEY + 1, KEY ^ 16'h8000, 16'hFFFF, KEY};
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; rd_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 key", v, 0);
    rd(2'd1, v); check("R1 timer", v, 0);
    rd(2'd2, v); check("R1 ctrl", v, 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 rst", int'(wdt_rst_o), 0);

    // R2 key sweep
    foreach (keys[i]) begin
      wr(2'd0, keys[i]);
      rd(2'd0, v); check("R2 key readback", v, (keys[i] == KEY) ? 1 : 0);
    end
    wr(2'd0, 16'h1234);
    rd(2'd0, v); check("R2 relock", v, 0);

    // R3 locked writes ignored
    wr(2'd0, KEY); wr(2'd1, 40); wr(2'd0, 0);
    wr(2'd1, 77); wr(2'd2, 7);
    repeat (3) @(negedge clk);
    rd(2'd1, v); check("R3 timer", v, 40);
    rd(2'd2, v); check("R3 ctrl", v, 0);
    check("R3 rst", int'(wdt_rst_o), 0);

    // R10 control bit positions (non-expiring values)
    wr(2'd0, KEY);
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, c);
      rd(2'd2, v); check("R10 ctrl readback", v, c);
    end
    wr(2'd2, 0);

    // R4 countdown and reload priority
    wr(2'd1, 50); wr(2'd2, 2);
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R4 countdown", v, 45);
    wr(2'd1, 200);
    rd(2'd1, v); check("R4 reload wins", v, 200);
    repeat (10) @(negedge clk);
    rd(2'd1, v); check("R4 continues", v, 190);
    wr(2'd2, 0);

    // R5 no reset without count-enable
    wr(2'd1, 0); wr(2'd2, 1);
    repeat (5) @(negedge clk);
    check("R5 rst needs cnt_en", int'(wdt_rst_o), 0);
    wr(2'd2, 0);

    // R5/R6/R7 sweep of start values
    for (int t = 0; t <= 20; t++) begin
      wr(2'd0, KEY); wr(2'd1, t); wr(2'd2, 3);
      wait_rst(k);
      if (t == 0) check("R6 immediate reset", k, 1);
      else        check("R5 expiry latency", k, t + 1);
      pulse_width(w);
      check("R7 pulse width", w, PLEN);
      rd(2'd0, v); check("R7 locked after", v, 0);
      rd(2'd1, v); check("R7 timer after", v, 0);
      rd(2'd2, v); check("R7 ctrl after", v, 0);
    end

    // R7 writes during pulse ignored
    wr(2'd0, KEY); wr(2'd1, 0); wr(2'd2, 3);
    wait_rst(k);
    wr(2'd0, KEY); wr(2'd1, 9); wr(2'd2, 6);
    pulse_width(w);
    check("R7 width with writes", w, PLEN - 6);
    rd(2'd0, v); check("R7 key write in pulse", v, 0);
    rd(2'd1, v); check("R7 timer write in pulse", v, 0);
    rd(2'd2, v); check("R7 ctrl write in pulse", v, 0);

    // R8 interrupt path sweep
    wr(2'd0, KEY);
    for (int t = 1; t <= 12; t++) begin
      wr(2'd2, 0); wr(2'd1, t); wr(2'd2, 6);
      k = 0;
      while (!irq_o && k < 200) begin @(negedge clk); k++; end
      check("R8 irq latency", k, t);
      repeat (4) @(negedge clk);
      rd(2'd1, v); check("R8 hold zero", v, 0);
      check("R8 irq held", int'(irq_o), 1);
      check("R8 no reset", int'(wdt_rst_o), 0);
    end
    wr(2'd2, 2);
    repeat (3) @(negedge clk);
    check("R8 irq off without enable", int'(irq_o), 0);
    rd(2'd1, v); check("R8 still zero", v, 0);
    wr(2'd2, 0);

    // R9 timer write collides with pending expiry
    wr(2'd1, 3); wr(2'd2, 3);
    repeat (2) @(negedge clk);
    wr(2'd1, 100);
    check("R9 pulse started", int'(wdt_rst_o), 1);
    pulse_width(w);
    rd(2'd1, v); check("R9 reload discarded", v, 0);

    summary();
    $finish;
  end

endmodule